// File: doc/BRIEF.md
# Condition Evaluator with Conditional Select

This block turns a 4-bit condition code and the processor status flags (zero, sign, carry, overflow, plus a dedicated saturation flag) into a single condition-true bit. That bit then drives three datapath operations. The first is a conditional move, which picks one of two 32-bit operands; the picked operand is either a register value or a sign-extended 5-bit immediate. The second is a set-flag operation, which produces the value 1 or 0. The third is a conditional branch, which produces a taken decision and a sign-extended 9-bit displacement.

The decoder presents the decoded fields and an operation kind for one cycle. The block evaluates the condition, forms the selected value, the write enable and the branch outputs, and registers all of them. They appear on the outputs one clock after the fields are applied. One encoding combines the always-true code with a zero displacement. For that case the block raises a trap request in place of a branch. Instruction fetch, the register file and flag updates live elsewhere.

Top module: `cond_select_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output register is cleared to zero at that edge.
- R2: `cond_true` equals, one clock after the inputs, the condition selected by `cond_code` as follows. 0: overflow. 1: carry. 2: zero. 3: carry OR zero. 4: sign. 5: always 1. 6: sign XOR overflow. 7: (sign XOR overflow) OR zero. 8 through 15 are the inverses of 0 through 7 respectively, except that 13 is the saturation flag.
- R3: For `op_kind` = 1 (conditional move) with `use_imm` = 0, `result` is `src_a` when the condition holds and `src_b` otherwise, and `result_we` is 1.
- R4: For `op_kind` = 1 with `use_imm` = 1, the operand chosen on a true condition is `imm5` sign-extended from bit 4 to 32 bits. On a false condition `src_b` is chosen.
- R5: For `op_kind` = 2 (set flag), `result` is the zero-extended value 1 when the condition holds and 0 otherwise, and `result_we` is 1.
- R6: For `op_kind` = 3 (branch), `br_offset` is the 9-bit value `{disp_hi, disp_lo, 0}` sign-extended from bit 8 to 32 bits. `br_taken` equals the condition.
- R7: A branch with `cond_code` = 5, `disp_hi` = 0 and `disp_lo` = 0 sets `trap_req` to 1 and `br_taken` to 0.
- R8: Outputs that the current operation does not produce are zero. `result` and `result_we` are zero unless `op_kind` is 1 or 2. `br_taken`, `br_offset` and `trap_req` are zero unless `op_kind` is 3 (`op_kind` = 0 is no operation).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_kind | input | 2 | 0 none, 1 conditional move, 2 set flag, 3 branch |
| cond_code | input | 4 | Condition selector |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_cy | input | 1 | Carry flag |
| flag_ov | input | 1 | Overflow flag |
| flag_sat | input | 1 | Saturation flag |
| use_imm | input | 1 | Conditional move takes the immediate as first operand |
| src_a | input | 32 | First register operand |
| imm5 | input | 5 | Immediate operand |
| src_b | input | 32 | Second register operand |
| disp_hi | input | 5 | Upper branch displacement field |
| disp_lo | input | 3 | Lower branch displacement field |
| cond_true | output | 1 | Registered condition result |
| result | output | 32 | Selected or set value |
| result_we | output | 1 | Destination write enable |
| br_taken | output | 1 | Branch taken |
| br_offset | output | 32 | Sign-extended branch displacement |
| trap_req | output | 1 | Always-branch to itself, reported as trap |

## Verification
Trap detection and the branch decision are resolved in the same cycle from the same code. When a branch uses code 5 with both displacement fields zero, the condition is true, yet the branch must not be taken. The bench provokes this with directed cases at and next to the zero displacement, and with a random stream in which such cases occur. It checks that `cond_true`, `trap_req` and `br_taken` agree with each other in that one output cycle. It also checks that a nonzero displacement under code 5 is an ordinary taken branch.

// File: rtl/csu_pkg.sv
// Shared types for the condition select unit.
// Assumes the operation kind is decoded upstream into two bits.
package csu_pkg;
    typedef enum logic [1:0] {
        OPK_NONE   = 2'd0,
        OPK_CMOV   = 2'd1,
        OPK_SETF   = 2'd2,
        OPK_BRANCH = 2'd3
    } csu_opk_e;

    localparam logic [3:0] CC_ALWAYS    = 4'h5;
    localparam logic [3:0] CC_SATURATED = 4'hD;
endpackage

// File: rtl/csu_cond_eval.sv
// Evaluates a 4-bit condition code against the status flags.
// Codes 8..15 invert codes 0..7, except the saturation slot.
module csu_cond_eval
    import csu_pkg::*;
(
    input  logic [3:0] code,
    input  logic       z,
    input  logic       s,
    input  logic       cy,
    input  logic       ov,
    input  logic       sat,
    output logic       hit
);
    logic base;

    // Base condition for the low three code bits.
    always_comb begin
        unique case (code[2:0])
            3'd0:    base = ov;
            3'd1:    base = cy;
            3'd2:    base = z;
            3'd3:    base = cy | z;
            3'd4:    base = s;
            3'd5:    base = 1'b1;
            3'd6:    base = s ^ ov;
            default: base = (s ^ ov) | z;
        endcase
    end

    // Apply inversion by the top bit, with the saturation slot replaced.
    always_comb begin
        if (code == CC_SATURATED) hit = sat;
        else                      hit = base ^ code[3];
    end
endmodule

// File: rtl/csu_value_sel.sv
// Forms the destination value for conditional move and set flag.
// Assumes the caller gates the write enable by operation kind.
module csu_value_sel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 5
) (
    input  logic              cond,
    input  logic              is_setf,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] src_a,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] value
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] first_op;

    // Sign-extend the immediate to the data width.
    always_comb imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};

    // Choose the operand used on a true condition.
    always_comb first_op = use_imm ? imm_ext : src_a;

    // Final value: flag value or conditional pick.
    always_comb begin
        if (is_setf) value = {{(DATA_W-1){1'b0}}, cond};
        else         value = cond ? first_op : src_b;
    end
endmodule

// File: rtl/csu_branch_calc.sv
// Builds the branch displacement and the taken / trap decision.
// Assumes displacement fields hold bits [8:4] and [3:1] of an even offset.
module csu_branch_calc
    import csu_pkg::*;
#(
    parameter int HI_W  = 5,
    parameter int LO_W  = 3,
    parameter int OFF_W = 32
) (
    input  logic             cond,
    input  logic [3:0]       code,
    input  logic [HI_W-1:0]  disp_hi,
    input  logic [LO_W-1:0]  disp_lo,
    output logic             taken,
    output logic             trap,
    output logic [OFF_W-1:0] offset
);
    localparam int DISP_W = HI_W + LO_W + 1;

    logic [DISP_W-1:0] disp;

    // Concatenate the fields into an even displacement.
    always_comb disp = {disp_hi, disp_lo, 1'b0};

    // Sign-extend from the top displacement bit.
    always_comb offset = {{(OFF_W-DISP_W){disp[DISP_W-1]}}, disp};

    // Always-true jump to itself is reported instead of taken.
    always_comb trap = (code == CC_ALWAYS) && (disp == '0);

    // Taken only for a real branch.
    always_comb taken = cond && !trap;
endmodule

// File: rtl/cond_select_unit.sv
// Top: one shared condition bit feeds move, set and branch paths.
// All outputs are registered one clock after the inputs; sync active-low reset.
module cond_select_unit
    import csu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 5,
    parameter int HI_W   = 5,
    parameter int LO_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_kind,
    input  logic [3:0]        cond_code,
    input  logic              flag_z,
    input  logic              flag_s,
    input  logic              flag_cy,
    input  logic              flag_ov,
    input  logic              flag_sat,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] src_a,
    input  logic [IMM_W-1:0]  imm5,
    input  logic [DATA_W-1:0] src_b,
    input  logic [HI_W-1:0]   disp_hi,
    input  logic [LO_W-1:0]   disp_lo,
    output logic              cond_true,
    output logic [DATA_W-1:0] result,
    output logic              result_we,
    output logic              br_taken,
    output logic [DATA_W-1:0] br_offset,
    output logic              trap_req
);
    csu_opk_e          opk;
    logic              hit;
    logic [DATA_W-1:0] value;
    logic              b_taken;
    logic              b_trap;
    logic [DATA_W-1:0] b_offset;
    logic              writes;
    logic              is_br;

    // Decode the operation kind.
    always_comb opk = csu_opk_e'(op_kind);
    always_comb writes = (opk == OPK_CMOV) || (opk == OPK_SETF);
    always_comb is_br  = (opk == OPK_BRANCH);

    csu_cond_eval u_eval (
        .code (cond_code),
        .z    (flag_z),
        .s    (flag_s),
        .cy   (flag_cy),
        .ov   (flag_ov),
        .sat  (flag_sat),
        .hit  (hit)
    );

    csu_value_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
        .cond    (hit),
        .is_setf (opk == OPK_SETF),
        .use_imm (use_imm),
        .src_a   (src_a),
        .imm     (imm5),
        .src_b   (src_b),
        .value   (value)
    );

    csu_branch_calc #(.HI_W(HI_W), .LO_W(LO_W), .OFF_W(DATA_W)) u_br (
        .cond    (hit),
        .code    (cond_code),
        .disp_hi (disp_hi),
        .disp_lo (disp_lo),
        .taken   (b_taken),
        .trap    (b_trap),
        .offset  (b_offset)
    );

    // Register all outputs, zeroing those the operation does not produce.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_true <= 1'b0;
            result    <= '0;
            result_we <= 1'b0;
            br_taken  <= 1'b0;
            br_offset <= '0;
            trap_req  <= 1'b0;
        end else begin
            cond_true <= hit;
            result    <= writes ? value : '0;
            result_we <= writes;
            br_taken  <= is_br && b_taken;
            br_offset <= is_br ? b_offset : '0;
            trap_req  <= is_br && b_trap;
        end
    end
endmodule

// File: rtl/csu_checker.sv
// Temporal checks on the condition select unit, bound to every instance.
module csu_checker #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        op_kind,
    input logic [3:0]        cond_code,
    input logic              use_imm,
    input logic [DATA_W-1:0] src_a,
    input logic [IMM_W-1:0]  imm5,
    input logic [DATA_W-1:0] src_b,
    input logic              cond_true,
    input logic [DATA_W-1:0] result,
    input logic              result_we,
    input logic              br_taken,
    input logic [DATA_W-1:0] br_offset,
    input logic              trap_req
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!result_we && !br_taken && !trap_req && !cond_true));

    a_r2_always_true: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(cond_code) == 4'h5 |-> cond_true);

    a_r3_cmov_reg: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(op_kind) == 2'd1 && !$past(use_imm)
        |-> result == (cond_true ? $past(src_a) : $past(src_b)));

    a_r4_cmov_imm: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(op_kind) == 2'd1 && $past(use_imm) && cond_true
        |-> result == {{(DATA_W-IMM_W){$past(imm5[IMM_W-1])}}, $past(imm5)});

    a_r5_setf_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(op_kind) == 2'd2 |-> result_we && result[0] == cond_true
        && result[DATA_W-1:1] == '0);

    a_r6_taken_is_branch: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> cond_true && $past(op_kind) == 2'd3);

    a_r7_trap_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> !br_taken && cond_true && br_offset == '0);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !result_we |-> result == '0);
endmodule

bind cond_select_unit csu_checker #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/cond_select_unit_bench.sv
// Bench: directed corners plus seeded random stream, checked by model functions.
module cond_select_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  op_kind;
    logic [3:0]  cond_code;
    logic        flag_z, flag_s, flag_cy, flag_ov, flag_sat, use_imm;
    logic [31:0] src_a, src_b;
    logic [4:0]  imm5, disp_hi;
    logic [2:0]  disp_lo;
    logic        cond_true, result_we, br_taken, trap_req;
    logic [31:0] result, br_offset;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;   // 250 MHz

    cond_select_unit u_cond_select_unit (.*);

    function automatic logic model_cond(input logic [3:0] c, input logic z, s, cy, ov, sat);
        case (c)
            4'h0: return ov;       4'h8: return !ov;
            4'h1: return cy;       4'h9: return !cy;
            4'h2: return z;        4'hA: return !z;
            4'h3: return cy || z;  4'hB: return !(cy || z);
            4'h4: return s;        4'hC: return !s;
            4'h5: return 1'b1;     4'hD: return sat;
            4'h6: return s != ov;  4'hE: return s == ov;
            4'h7: return (s != ov) || z;
            default: return !((s != ov) || z);
        endcase
    endfunction

    function automatic logic [31:0] model_off(input logic [4:0] hi, input logic [2:0] lo);
        int v;
        v = int'(hi) * 16 + int'(lo) * 2;
        if (v >= 256) v = v - 512;
        return 32'(v);
    endfunction

    task automatic drive(input logic [1:0] k, input logic [3:0] c, input logic [4:0] fl,
                         input logic ui, input logic [31:0] a, input logic [4:0] im,
                         input logic [31:0] b, input logic [4:0] hi, input logic [2:0] lo);
        @(negedge clk);
        op_kind = k; cond_code = c;
        {flag_z, flag_s, flag_cy, flag_ov, flag_sat} = fl;
        use_imm = ui; src_a = a; imm5 = im; src_b = b; disp_hi = hi; disp_lo = lo;
    endtask

    task automatic fail_line(input string req, input string what, input logic [31:0] act, exp);
        n_fail++;
        $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    endtask

    // Compare all outputs one clock after the drive, at the next falling edge.
    task automatic check_all(input string req);
        logic        c, we, tk, tr;
        logic [31:0] r, off, imx;
        c   = model_cond(cond_code, flag_z, flag_s, flag_cy, flag_ov, flag_sat);
        imx = {{27{imm5[4]}}, imm5};
        we  = (op_kind == 2'd1) || (op_kind == 2'd2);
        r   = (op_kind == 2'd1) ? (c ? (use_imm ? imx : src_a) : src_b)
            : (op_kind == 2'd2) ? {31'd0, c} : 32'd0;
        tr  = (op_kind == 2'd3) && cond_code == 4'h5 && disp_hi == 0 && disp_lo == 0;
        tk  = (op_kind == 2'd3) && c && !tr;
        off = (op_kind == 2'd3) ? model_off(disp_hi, disp_lo) : 32'd0;
        @(negedge clk);
        n_checks++;
        if (cond_true !== c)   fail_line(req, "cond_true", 32'(cond_true), 32'(c));
        if (result !== r)      fail_line(req, "result", result, r);
        if (result_we !== we)  fail_line(req, "result_we", 32'(result_we), 32'(we));
        if (br_taken !== tk)   fail_line(req, "br_taken", 32'(br_taken), 32'(tk));
        if (br_offset !== off) fail_line(req, "br_offset", br_offset, off);
        if (trap_req !== tr)   fail_line(req, "trap_req", 32'(trap_req), 32'(tr));
    endtask

    task automatic run(input string req, input logic [1:0] k, input logic [3:0] c,
                       input logic [4:0] fl, input logic ui, input logic [31:0] a,
                       input logic [4:0] im, input logic [31:0] b,
                       input logic [4:0] hi, input logic [2:0] lo);
        drive(k, c, fl, ui, a, im, b, hi, lo);
        check_all(req);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0C0D));
        rst_n = 1'b0;
        drive(2'd3, 4'h5, 5'h1F, 1'b1, 32'hFFFF_FFFF, 5'h1F, 32'hFFFF_FFFF, 5'h10, 3'd7);
        @(negedge clk); @(negedge clk);
        // R1: outputs cleared under reset even with busy inputs
        n_checks++;
        if ({cond_true, result_we, br_taken, trap_req} !== 4'b0 || result !== 0 || br_offset !== 0)
            fail_line("R1", "reset outputs", {cond_true, result_we, br_taken, trap_req}, 32'd0);
        rst_n = 1'b1;

        // R2: every code under several flag patterns (set flag path, R5 too)
        for (int c = 0; c < 16; c++)
            for (int f = 0; f < 32; f += 5)
                run("R2", 2'd2, 4'(c), 5'(f), 1'b0, 32'd0, 5'd0, 32'd0, 5'd0, 3'd0);
        run("R5", 2'd2, 4'h2, 5'b10000, 1'b0, 32'hDEAD_BEEF, 5'd3, 32'h1234_5678, 5'd0, 3'd0);
        run("R5", 2'd2, 4'hA, 5'b10000, 1'b0, 32'hDEAD_BEEF, 5'd3, 32'h1234_5678, 5'd0, 3'd0);
        // R3: register conditional move both ways
        run("R3", 2'd1, 4'h1, 5'b00100, 1'b0, 32'hAAAA_0001, 5'd0, 32'h5555_0002, 5'd0, 3'd0);
        run("R3", 2'd1, 4'h1, 5'b00000, 1'b0, 32'hAAAA_0001, 5'd0, 32'h5555_0002, 5'd0, 3'd0);
        // R4: immediate form, negative and positive
        run("R4", 2'd1, 4'h5, 5'b0, 1'b1, 32'h1, 5'h10, 32'h2, 5'd0, 3'd0);
        run("R4", 2'd1, 4'h5, 5'b0, 1'b1, 32'h1, 5'h0F, 32'h2, 5'd0, 3'd0);
        run("R4", 2'd1, 4'hD, 5'b0, 1'b1, 32'h1, 5'h1F, 32'h2, 5'd0, 3'd0);
        // R6: offset extremes
        run("R6", 2'd3, 4'h5, 5'b0, 1'b0, 32'd0, 5'd0, 32'd0, 5'h10, 3'd0);
        run("R6", 2'd3, 4'h5, 5'b0, 1'b0, 32'd0, 5'd0, 32'd0, 5'h0F, 3'd7);
        run("R6", 2'd3, 4'h2, 5'b0, 1'b0, 32'd0, 5'd0, 32'd0, 5'h1F, 3'd7);
        // R7: trap and its neighbours
        run("R7", 2'd3, 4'h5, 5'b0, 1'b0, 32'd0, 5'd0, 32'd0, 5'h00, 3'd0);
        run("R7", 2'd3, 4'h5, 5'b0, 1'b0, 32'd0, 5'd0, 32'd0, 5'h00, 3'd1);
        run("R7", 2'd3, 4'hB, 5'b0, 1'b0, 32'd0, 5'd0, 32'd0, 5'h00, 3'd0);
        run("R7", 2'd1, 4'h5, 5'b0, 1'b0, 32'h7, 5'd0, 32'd9, 5'h00, 3'd0);
        // R8: no operation leaves everything quiet
        run("R8", 2'd0, 4'h5, 5'h1F, 1'b1, 32'hFFFF_FFFF, 5'h1F, 32'h1, 5'h1F, 3'd7);

        // Random stream, displacements biased toward zero to hit the trap
        for (int i = 0; i < 2000; i++) begin
            logic [4:0] hi;
            logic [2:0] lo;
            hi = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
            lo = ($urandom % 2 == 0) ? 3'd0 : 3'($urandom);
            run("R2-random", 2'($urandom), 4'($urandom), 5'($urandom), 1'($urandom),
                $urandom, 5'($urandom), $urandom, hi, lo);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule